// File: doc/BRIEF.md
# Selectable-Sample SPI Shift Port

This block moves one byte at a time over a four-wire synchronous serial link. It acts either as bus master, making its own serial clock from the system clock, or as a slave that follows an external serial clock while an active-low select is held low. Bits leave and enter most significant bit first. The host side writes the next byte to send and reads the last byte received. Three sticky flags report buffer occupancy, overflow and write collisions.

Three controls set the wire timing. One sets the resting level of the serial clock. One picks which clock edge moves a new bit onto the output. One applies to master mode only and chooses where the input is captured: at the middle of each output bit time or at its end. In master mode a 2-bit control divides the system clock by 4, 16 or 64. In slave mode the serial clock, select and data inputs pass through two-stage synchronizers, and their edges are found in the system clock domain.

Top module: `spi_sel_port`

## Requirements
- R1: In master mode, SCK half period is 2, 8 or 32 system clocks for `div_sel` 0, 1 or 2/3 (divide by 4, 16, 64). `busy` stays high for exactly 16 half periods after an accepted write.
- R2: `sck_o` rests at the level of `idle_hi` whenever no master transfer is running, and always in slave mode.
- R3: The output bit on `sdo` changes only on a rising SCK edge when `idle_hi` XOR `lead_launch` is 1, and only on a falling edge otherwise. With `lead_launch` = 0, bit 7 is on `sdo` from the write, before the first edge.
- R4: Bytes are sent and received most significant bit first. A receiver that samples `sdo` on the SCK edges of the non-launching direction collects the written byte.
- R5: In master mode with `late_sample` = 0, `sdi` is captured at the middle of each output bit time, on the non-launching edge. With `late_sample` = 1 it is captured at the end, the moment the next bit is launched.
- R6: In slave mode `late_sample` has no effect. Data is always captured on the non-launching edge of `sck_i`.
- R7: In slave mode the block shifts only while `sel_n_i` is low. Deasserting `sel_n_i` discards a partial byte, so the next selection starts from bit 7.
- R8: `buf_full` goes to 1 when a byte completes and `rd_data` then shows it. A one-cycle `rd_en` clears `buf_full`.
- R9: A byte that completes while `buf_full` is 1 sets `rx_overflow` and leaves `rd_data` unchanged. `rd_en` clears `rx_overflow`.
- R10: `wr_en` while `busy` is 1 is ignored: the transfer in flight is not altered and `wr_collide` goes to 1. The next accepted write clears `wr_collide`.
- R11: After reset `buf_full`, `rx_overflow`, `wr_collide` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| idle_hi | input | 1 | Resting SCK level |
| lead_launch | input | 1 | Launch-edge select (see R3) |
| late_sample | input | 1 | Master capture at end of bit time |
| div_sel | input | 2 | Master clock divider select |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Received byte buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| wr_collide | output | 1 | Write attempted during transfer |
| rx_overflow | output | 1 | Byte lost to a full buffer |
| busy | output | 1 | Transfer active (master) or selected (slave) |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Slave serial clock |
| sel_n_i | input | 1 | Slave select, active low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is the difference between middle and end capture in master mode. Over one bit time the data line must hold one value in the first half and another in the second, in step with the clock the block makes itself. The bench contains a reactive far-end model that watches `sck_o`, counts its edges and drives `sdi` from two unrelated bytes, one for each half of every bit. The received byte must then equal one byte or the other. The model also reconstructs `sdo` on the non-launching edges and flags any output change off a launch edge. This model runs over all polarity, launch-edge, capture-point and divider settings.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    localparam int HALF_MAX = 32;
    localparam int HCNT_W   = $clog2(HALF_MAX);

    typedef enum logic [1:0] {
        DIV_BY_4   = 2'd0,
        DIV_BY_16  = 2'd1,
        DIV_BY_64  = 2'd2,
        DIV_BY_64B = 2'd3
    } div_sel_t;

    typedef struct packed {
        logic master;
        logic idle_hi;
        logic lead;
        logic late;
    } spi_cfg_t;

    typedef struct packed {
        logic mid;
        logic fin;
        logic last;
    } mev_t;

    typedef struct packed {
        logic samp;
        logic launch;
        logic sel;
    } sev_t;

    function automatic logic [HCNT_W-1:0] half_len_m1(input logic [1:0] sel);
        logic [HCNT_W-1:0] r;
        case (div_sel_t'(sel))
            DIV_BY_4:  r = HCNT_W'(1);
            DIV_BY_16: r = HCNT_W'(7);
            default:   r = HCNT_W'(HALF_MAX - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg1;
    logic [W-1:0] stg2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1 <= RST_VAL;
            stg2 <= RST_VAL;
        end else begin
            stg1 <= d;
            stg2 <= stg1;
        end
    end

    assign q = stg2;
endmodule

// File: rtl/spi_sel_mseq.sv
module spi_sel_mseq
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] div_sel,
    input  logic       lead,
    output logic       busy,
    output mev_t       ev,
    output logic       sck_act
);
    localparam int NEV  = 2 * DATA_W;
    localparam int EV_W = $clog2(NEV + 1);
    localparam logic [EV_W-1:0] NEV_V = EV_W'(NEV);

    logic [HCNT_W-1:0] cnt;
    logic [HCNT_W-1:0] lim;
    logic [EV_W-1:0]   idx;
    logic [EV_W-1:0]   nidx;
    logic              tick;

    assign tick = busy && (cnt == lim);
    assign nidx = idx + EV_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            lim  <= '0;
            idx  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            lim  <= half_len_m1(div_sel);
            idx  <= '0;
        end else if (tick) begin
            cnt <= '0;
            idx <= nidx;
            if (nidx == NEV_V) busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + HCNT_W'(1);
        end
    end

    always_comb begin
        ev.mid  = tick &  nidx[0];
        ev.fin  = tick & ~nidx[0];
        ev.last = tick & (nidx == NEV_V);
    end

    // even half-steps are active when launching on the leaving-idle edge
    assign sck_act = busy & (idx[0] ^ lead);

    AST_MSEQ_STARTS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                   // R1
    AST_HALF_CADENCE: assert property (@(posedge clk) disable iff (rst)
        (ev.mid || ev.fin) |=> !(ev.mid || ev.fin));                   // R1
    AST_LAST_IS_FIN: assert property (@(posedge clk) disable iff (rst)
        ev.last |=> !busy);                                            // R1
endmodule

// File: rtl/spi_sel_sedge.sv
module spi_sel_sedge
    import spi_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic idle_hi,
    input  logic lead,
    input  logic sck_i,
    input  logic sel_n_i,
    input  logic sdi_i,
    output sev_t sev,
    output logic sdi_s
);
    logic [2:0] raw;
    logic [2:0] synced;
    logic       sck_s;
    logic       seln_s;
    logic       sck_d;
    logic       changed;
    logic       leading;
    logic       trailing;

    assign raw = {sck_i, sel_n_i, sdi_i};

    spi_sel_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign sck_s  = synced[2];
    assign seln_s = synced[1];
    assign sdi_s  = synced[0];

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign changed  = sck_s != sck_d;
    assign leading  = changed && (sck_d == idle_hi);
    assign trailing = changed && (sck_s == idle_hi);

    always_comb begin
        sev.sel    = en & ~seln_s;
        sev.samp   = sev.sel & (lead ? trailing : leading);
        sev.launch = sev.sel & (lead ? leading  : trailing);
    end

    AST_SEDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sev.samp && sev.launch));                                    // R7
endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              late_eff,
    input  logic              load,
    input  logic              wr_try,
    input  logic              busy,
    input  logic [DATA_W-1:0] wr_data,
    input  mev_t              mev,
    input  sev_t              sev,
    input  logic              sdi_m,
    input  logic              sdi_s,
    input  logic              rd_en,
    output logic              sdo,
    output logic [DATA_W-1:0] rd_data,
    output logic              bf,
    output logic              ovf,
    output logic              wcol
);
    localparam int SB_W = $clog2(DATA_W);
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rxbuf;
    logic [SB_W-1:0]   sbits;
    logic              mid_bit;
    logic              out_q;
    logic              in_bit;
    logic              done;
    logic              bf_keep;
    logic [DATA_W-1:0] rx_word;

    always_comb begin
        in_bit  = is_master ? (late_eff ? sdi_m : mid_bit) : sdi_s;
        rx_word = {shreg[MSB-1:0], in_bit};
        done    = is_master ? mev.last
                            : (sev.samp && (sbits == SB_W'(DATA_W - 1)));
        bf_keep = bf & ~rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            mid_bit <= 1'b0;
            out_q   <= 1'b0;
        end else if (load) begin
            shreg <= wr_data;
            out_q <= wr_data[MSB];
        end else if (is_master) begin
            if (mev.mid) mid_bit <= sdi_m;
            if (mev.fin) shreg   <= rx_word;
        end else begin
            if (sev.samp)   shreg <= rx_word;
            if (sev.launch) out_q <= shreg[MSB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || is_master || !sev.sel) sbits <= '0;
        else if (sev.samp)
            sbits <= (sbits == SB_W'(DATA_W - 1)) ? '0 : sbits + SB_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxbuf <= '0;
            bf    <= 1'b0;
            ovf   <= 1'b0;
            wcol  <= 1'b0;
        end else begin
            if (done && !bf_keep) rxbuf <= rx_word;
            bf  <= bf_keep | done;
            ovf <= (ovf & ~rd_en) | (done & bf_keep);
            if (wr_try && busy) wcol <= 1'b1;
            else if (load)      wcol <= 1'b0;
        end
    end

    assign sdo     = is_master ? shreg[MSB] : out_q;
    assign rd_data = rxbuf;

    AST_BF_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> bf);                                                  // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (done && bf && !rd_en) |=> ($stable(rxbuf) && ovf));           // R9
    AST_OVF_NEEDS_BF: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(bf));                                     // R9
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_try && busy) |=> wcol);                                    // R10
endmodule

// File: rtl/spi_sel_port.sv
module spi_sel_port
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              idle_hi,
    input  logic              lead_launch,
    input  logic              late_sample,
    input  logic [1:0]        div_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              wr_collide,
    output logic              rx_overflow,
    output logic              busy,
    output logic              sck_o,
    input  logic              sck_i,
    input  logic              sel_n_i,
    output logic              sdo,
    input  logic              sdi
);
    spi_cfg_t cfg;
    mev_t     mev;
    sev_t     sev;
    logic     m_busy;
    logic     sck_act;
    logic     sdi_s;
    logic     load;

    always_comb begin
        cfg.master  = master_mode;
        cfg.idle_hi = idle_hi;
        cfg.lead    = lead_launch;
        cfg.late    = late_sample & master_mode;
    end

    assign busy = cfg.master ? m_busy : sev.sel;
    assign load = wr_en & ~busy;

    spi_sel_mseq #(.DATA_W(DATA_W)) u_mseq (
        .clk     (clk),
        .rst     (rst),
        .start   (load & cfg.master),
        .div_sel (div_sel),
        .lead    (cfg.lead),
        .busy    (m_busy),
        .ev      (mev),
        .sck_act (sck_act)
    );

    spi_sel_sedge u_sedge (
        .clk     (clk),
        .rst     (rst),
        .en      (~cfg.master),
        .idle_hi (cfg.idle_hi),
        .lead    (cfg.lead),
        .sck_i   (sck_i),
        .sel_n_i (sel_n_i),
        .sdi_i   (sdi),
        .sev     (sev),
        .sdi_s   (sdi_s)
    );

    spi_sel_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .is_master (cfg.master),
        .late_eff  (cfg.late),
        .load      (load),
        .wr_try    (wr_en),
        .busy      (busy),
        .wr_data   (wr_data),
        .mev       (mev),
        .sev       (sev),
        .sdi_m     (sdi),
        .sdi_s     (sdi_s),
        .rd_en     (rd_en),
        .sdo       (sdo),
        .rd_data   (rd_data),
        .bf        (buf_full),
        .ovf       (rx_overflow),
        .wcol      (wr_collide)
    );

    assign sck_o = cfg.idle_hi ^ (cfg.master & sck_act);

    AST_SLAVE_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (sck_o == idle_hi));                          // R2
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !busy) |-> (sck_o == idle_hi));                // R2
endmodule

// File: tb/spi_sel_port_tb.sv
`timescale 1ns/100ps
module spi_sel_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_mode = 1'b1;
    logic       idle_hi = 1'b0;
    logic       lead_launch = 1'b0;
    logic       late_sample = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       buf_full, wr_collide, rx_overflow, busy, sck_o, sdo;
    logic       sck_i = 1'b0;
    logic       sel_n_i = 1'b1;
    logic       sdi;

    int n_chk = 0;
    int n_fail = 0;

    // far-end model state
    logic       obs_on = 1'b0;
    logic       cur_pol = 1'b0, cur_es = 1'b0;
    logic [7:0] xv = 8'h00, yv = 8'h00;
    logic       sdi_obs, sdi_drv = 1'b0;
    logic [7:0] tbcap;
    int         edge_n, dir_err, ev_i;
    logic       prev_sck, prev_sdo, prev_busy, is_launch;

    assign sdi = master_mode ? sdi_obs : sdi_drv;

    always #2.5 clk = ~clk;

    spi_sel_port u_dut (
        .clk(clk), .rst(rst), .master_mode(master_mode), .idle_hi(idle_hi),
        .lead_launch(lead_launch), .late_sample(late_sample), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .buf_full(buf_full), .wr_collide(wr_collide), .rx_overflow(rx_overflow),
        .busy(busy), .sck_o(sck_o), .sck_i(sck_i), .sel_n_i(sel_n_i),
        .sdo(sdo), .sdi(sdi)
    );

    always @(negedge clk) begin
        if (!obs_on) begin
            edge_n  = 0;
            dir_err = 0;
            tbcap   = 8'h00;
            sdi_obs = xv[7];
        end else begin
            is_launch = (sck_o !== prev_sck) && ((sck_o == 1'b1) == (cur_pol ^ cur_es));
            if (sck_o !== prev_sck) begin
                ev_i = edge_n + (cur_es ? 0 : 1);
                if (!is_launch) tbcap = {tbcap[6:0], sdo};
                if (ev_i < 16)
                    sdi_obs = (ev_i % 2 == 0) ? xv[7 - ev_i/2] : yv[7 - ev_i/2];
                edge_n++;
            end
            if (busy && prev_busy && (sdo !== prev_sdo) && !is_launch) dir_err++;
        end
        prev_sck  = sck_o;
        prev_sdo  = sdo;
        prev_busy = busy;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic mxfer(input logic pol, input logic es, input logic late,
                         input logic [1:0] dsel, input logic [7:0] tx,
                         input logic [7:0] x, input logic [7:0] y, input logic do_read);
        int h;
        int cyc;
        h = (dsel == 2'd0) ? 2 : (dsel == 2'd1) ? 8 : 32;
        @(negedge clk);
        master_mode = 1'b1; idle_hi = pol; lead_launch = es; late_sample = late;
        div_sel = dsel; xv = x; yv = y; cur_pol = pol; cur_es = es;
        repeat (2) @(negedge clk);
        check("R2 idle level before transfer", sck_o, pol);
        obs_on = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_data = tx;
        @(negedge clk);
        wr_en = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check("R1 busy length", cyc, 16 * h);
        check("R3 sdo moves only on launch edges", dir_err, 0);
        check("R4 far end collects byte MSB first", tbcap, tx);
        check("R8 buf_full after byte", buf_full, 1'b1);
        check("R2 idle level after transfer", sck_o, pol);
        if (do_read) begin
            check("R5 capture point selects mid or end data", rd_data, late ? y : x);
            host_read();
            check("R8 read clears buf_full", buf_full, 1'b0);
        end
        obs_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic sxfer(input logic pol, input logic es, input logic late,
                         input logic [7:0] tx_s, input logic [7:0] m, input int nbits);
        logic [7:0] cap;
        @(negedge clk);
        master_mode = 1'b0; idle_hi = pol; lead_launch = es; late_sample = late;
        sck_i = pol; sel_n_i = 1'b1; sdi_drv = m[7];
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_data = tx_s;
        @(negedge clk);
        wr_en = 1'b0;
        sel_n_i = 1'b0;
        repeat (6) @(negedge clk);
        cap = 8'h00;
        for (int j = 0; j < nbits; j++) begin
            if (es) begin
                sck_i = ~pol; sdi_drv = m[7 - j];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], sdo}; sck_i = pol;
                repeat (8) @(negedge clk);
            end else begin
                sdi_drv = m[7 - j];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], sdo}; sck_i = ~pol;
                repeat (8) @(negedge clk);
                sck_i = pol;
                repeat (8) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        check("R2 slave leaves sck_o idle", sck_o, pol);
        sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
        if (nbits == 8) begin
            check("R7 slave buf_full", buf_full, 1'b1);
            check("R6 slave capture ignores late_sample", rd_data, m);
            check("R4 slave sends MSB first", cap, tx_s);
            host_read();
        end else begin
            check("R7 partial byte not delivered", buf_full, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 buf_full at reset", buf_full, 1'b0);
        check("R11 rx_overflow at reset", rx_overflow, 1'b0);
        check("R11 wr_collide at reset", wr_collide, 1'b0);
        check("R11 busy at reset", busy, 1'b0);

        // master sweep over every timing setting
        for (int i = 0; i < 32; i++) begin
            mxfer(i[0], i[1], i[2], i[4:3], 8'(i * 37 + 90), 8'(i * 101 + 7),
                  8'(~(i * 53 + 11)), 1'b1);
        end

        // slave sweep
        for (int k = 0; k < 8; k++) begin
            sxfer(k[0], k[1], k[2], 8'(k * 29 + 17), 8'(k * 71 + 200), 8);
        end

        // R7: deselect mid-byte, then a full byte must still align
        sxfer(1'b0, 1'b0, 1'b0, 8'h3C, 8'hE1, 3);
        sxfer(1'b0, 1'b0, 1'b0, 8'h96, 8'h4B, 8);

        // R9: second byte while first is unread
        mxfer(1'b0, 1'b1, 1'b0, 2'd0, 8'h11, 8'hC3, 8'h0F, 1'b0);
        mxfer(1'b1, 1'b0, 1'b1, 2'd0, 8'h22, 8'h55, 8'hAA, 1'b0);
        check("R9 overflow flagged", rx_overflow, 1'b1);
        check("R9 buffer keeps first byte", rd_data, 8'hC3);
        host_read();
        check("R9 read clears overflow", rx_overflow, 1'b0);
        check("R8 read clears buf_full", buf_full, 1'b0);

        // R10: write during a master transfer
        @(negedge clk);
        master_mode = 1'b1; idle_hi = 1'b0; lead_launch = 1'b1; late_sample = 1'b0;
        div_sel = 2'd1; xv = 8'h5A; yv = 8'h00; cur_pol = 1'b0; cur_es = 1'b1;
        repeat (2) @(negedge clk);
        obs_on = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hB4;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 collision flagged", wr_collide, 1'b1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R10 transfer unaltered", tbcap, 8'hB4);
        check("R10 received unaltered", rd_data, 8'h5A);
        host_read();
        obs_on = 1'b0;
        @(negedge clk);
        mxfer(1'b0, 1'b0, 1'b0, 2'd0, 8'h81, 8'h7E, 8'h18, 1'b1);
        check("R10 accepted write clears collision", wr_collide, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule